// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

This block recovers characters from an asynchronous serial line. The line is sampled at sixteen times the bit rate, as paced by a one-cycle tick input, through a two-stage synchroniser. A framing engine locates each start bit, then collects the data bits least significant first, an optional parity bit and the stop bit. It writes the character into a 16-entry receive queue. Each queue entry keeps the character together with its own parity, framing and break marks.

The surrounding logic sees a five-bit line status word and the character at the queue head. The per-character error marks reach the status word only when their character becomes the queue head. A status-read strobe clears every sticky flag except data ready. A pop strobe retires the head character.

The framing engine handles three line faults:
- A bad stop bit is taken as the start of the next character.
- A line held low for a whole character yields one all-zero break entry. The receiver then waits for the line to go high again.
- A character that completes while the queue is full is dropped, and the overrun flag is raised.

Top module: `uart_rx_lsr`

## Requirements
- R1: The status word is {break[4], framing[3], parity[2], overrun[1], data_ready[0]}. After reset all five bits are 0 and `head_data` is 0.
- R2: Data ready (bit 0) is 1 exactly while the queue holds at least one character. It drops to 0 in the cycle after the pop that empties the queue.
- R3: When a character completes while the queue holds 16 entries, overrun (bit 1) is set in the next cycle. The character is discarded, and the queue contents and head stay unchanged.
- R4: A `status_rd` pulse clears bits 1 to 4 in the next cycle and leaves data ready unchanged. If a new error event arrives in the same cycle, its flag stays set.
- R5: With `par_en`=1, the parity bit follows the data bits. `par_odd`=1 selects odd parity and 0 selects even parity. A received parity bit of the wrong value marks the character, and parity (bit 2) is set.
- R6: A stop bit sampled as 0 marks the character, and framing (bit 3) is set.
- R7: After a framing error, the bad stop bit is treated as the next start bit. The following character is received from the very next bit time.
- R8: A line held low through start, data, parity (if enabled) and stop pushes one entry with data 0x00 and only its break mark set. Break is bit 4.
- R9: After a break, the receiver pushes nothing more until the line has returned high.
- R10: A low pulse that is high again at the mid-bit sample of the start bit is ignored and pushes no character.
- R11: `data_len` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Bits arrive least significant first, and `head_data` shows the character zero-extended.
- R12: The parity, framing and break flags are raised only when their character becomes the queue head. An error on a character queued behind another does not show until the earlier one is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversample enable, 16 pulses per bit time |
| rx | input | 1 | Asynchronous serial line, idle high |
| data_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 for odd parity, 0 for even |
| pop | input | 1 | Retire the head character |
| status_rd | input | 1 | Status read strobe, clears the sticky flags |
| head_data | output | 8 | Character at the queue head, 0 when empty |
| status | output | 5 | Line status word |

## Verification
A bit counter or sample phase that drifts shows up as a wrong `head_data` value for the character just received, about one bit time after its stop bit. A state machine that misses the break or resync path shows up as an extra or missing queue entry. The bench catches this through the data ready bit when it pops. Wrong pointer or count state surfaces as an early or late fall of data ready, or as the wrong head after overrun. Misplaced error marks show as parity, framing or break flags appearing in the cycle after the wrong pop.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int DATA_W = 8;

  // Queue entry: character plus its own error marks
  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_PAR,
    RS_STOP,
    RS_BRK
  } rx_state_e;

  localparam int ST_DR  = 0;
  localparam int ST_OVR = 1;
  localparam int ST_PAR = 2;
  localparam int ST_FRM = 3;
  localparam int ST_BRK = 4;
  localparam int ST_W   = 5;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      rx_i,
  input  logic [1:0] len_i,
  input  logic      pen_i,
  input  logic      podd_i,
  output logic      push_o,
  output rx_entry_t entry_o,
  output logic      brk_idle_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [2:0]        bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              pbit_q, pbit_d;
  logic              zero_q, zero_d;

  logic [2:0]        last_bit;
  logic [DATA_W-1:0] aligned;
  logic              par_bad;
  logic              at_end;

  always_comb begin
    last_bit = 3'd4 + {1'b0, len_i};
    aligned  = sh_q >> (3'd3 - {1'b0, len_i});
    par_bad  = pen_i & ((^aligned) ^ pbit_q ^ podd_i);
    at_end   = (cnt_q == LAST);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    pbit_d  = pbit_q;
    zero_d  = zero_q;
    push_o  = 1'b0;
    entry_o = '0;
    if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
      unique case (state_q)
        RS_IDLE: begin
          if (!rx_i) begin
            state_d = RS_START;
            cnt_d   = '0;
          end
        end
        RS_START: begin
          if (cnt_q == MID) begin
            cnt_d = '0;
            if (!rx_i) begin
              state_d = RS_DATA;
              bit_d   = '0;
              zero_d  = 1'b1;
            end else begin
              state_d = RS_IDLE;
            end
          end
        end
        RS_DATA: begin
          if (at_end) begin
            sh_d   = {rx_i, sh_q[DATA_W-1:1]};
            zero_d = zero_q & ~rx_i;
            bit_d  = bit_q + 1'b1;
            if (bit_q == last_bit) state_d = pen_i ? RS_PAR : RS_STOP;
          end
        end
        RS_PAR: begin
          if (at_end) begin
            pbit_d  = rx_i;
            zero_d  = zero_q & ~rx_i;
            state_d = RS_STOP;
          end
        end
        RS_STOP: begin
          if (at_end) begin
            push_o = 1'b1;
            if (zero_q && !rx_i) begin
              entry_o.brk = 1'b1;
              state_d     = RS_BRK;
            end else begin
              entry_o.data = aligned;
              entry_o.par  = par_bad;
              entry_o.frm  = ~rx_i;
              if (rx_i) begin
                state_d = RS_IDLE;
              end else begin
                // bad stop bit doubles as the next start bit
                state_d = RS_DATA;
                bit_d   = '0;
                zero_d  = 1'b1;
              end
            end
          end
        end
        RS_BRK: begin
          if (rx_i) state_d = RS_IDLE;
        end
        default: state_d = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      zero_q  <= 1'b0;
    end else if (tick_i) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      pbit_q  <= pbit_d;
      zero_q  <= zero_d;
    end
  end

  assign brk_idle_o = (state_q == RS_BRK);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  rx_entry_t     din_i,
  input  logic          pop_i,
  output rx_entry_t     head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o,
  output logic          head_new_o,
  output rx_entry_t     next_head_o
);
  // DEPTH must be a power of two: pointers wrap naturally
  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  always_comb begin
    empty_o = (cnt_q == '0);
    full_o  = (cnt_q == CW'(DEPTH));
    push_ok = push_i & ~full_o;
    pop_ok  = pop_i & ~empty_o;
    wr_d    = push_ok ? wr_q + 1'b1 : wr_q;
    rd_d    = pop_ok  ? rd_q + 1'b1 : rd_q;
    cnt_d   = cnt_q + CW'(push_ok) - CW'(pop_ok);
    if (pop_ok) head_new_o = (cnt_q > CW'(1)) | push_ok;
    else        head_new_o = push_ok & empty_o;
    next_head_o = (pop_ok && cnt_q > CW'(1)) ? mem[rd_q + 1'b1] : din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din_i;
  end

  assign head_o  = mem[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
  import uart_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_i,
  input  logic      ovf_i,
  input  logic      head_new_i,
  input  rx_entry_t next_head_i,
  output logic      ovr_o,
  output logic      par_o,
  output logic      frm_o,
  output logic      brk_o
);
  logic [3:0] flg_q, flg_d, evt;

  always_comb begin
    evt   = {head_new_i & next_head_i.brk,
             head_new_i & next_head_i.frm,
             head_new_i & next_head_i.par,
             ovf_i};
    // a fresh event outranks the clearing read
    flg_d = (rd_i ? 4'b0 : flg_q) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign {brk_o, frm_o, par_o, ovr_o} = flg_q;
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  parameter int SYNC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        rx,
  input  logic [1:0]  data_len,
  input  logic        par_en,
  input  logic        par_odd,
  input  logic        pop,
  input  logic        status_rd,
  output logic [7:0]  head_data,
  output logic [4:0]  status
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          rx_s;
  logic          frame_push, brk_idle;
  rx_entry_t     frame_entry, head, next_head;
  logic          q_empty, q_full, head_new, ovf_evt;
  logic [CW-1:0] q_count;
  logic          f_ovr, f_par, f_frm, f_brk;

  uart_rx_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx), .q_o(rx_s)
  );

  uart_rx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_s),
    .len_i(data_len), .pen_i(par_en), .podd_i(par_odd),
    .push_o(frame_push), .entry_o(frame_entry), .brk_idle_o(brk_idle)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(frame_push), .din_i(frame_entry),
    .pop_i(pop), .head_o(head), .empty_o(q_empty), .full_o(q_full),
    .count_o(q_count), .head_new_o(head_new), .next_head_o(next_head)
  );

  assign ovf_evt = frame_push & q_full;

  uart_rx_stat u_stat (
    .clk(clk), .rst_n(rst_n), .rd_i(status_rd), .ovf_i(ovf_evt),
    .head_new_i(head_new), .next_head_i(next_head),
    .ovr_o(f_ovr), .par_o(f_par), .frm_o(f_frm), .brk_o(f_brk)
  );

  always_comb begin
    status         = '0;
    status[ST_DR]  = ~q_empty;
    status[ST_OVR] = f_ovr;
    status[ST_PAR] = f_par;
    status[ST_FRM] = f_frm;
    status[ST_BRK] = f_brk;
    head_data      = q_empty ? 8'h00 : head.data;
  end
endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pop,
  input logic          status_rd,
  input logic [4:0]    status,
  input logic [7:0]    head_data,
  input logic          ovf_evt,
  input logic          frame_push,
  input logic          push_brk,
  input logic          push_frm,
  input logic          push_par,
  input logic          brk_idle,
  input logic [CW-1:0] q_count
);
  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> status[1]); // R3
  AST_OVR_KEEPS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !pop) |=> ($stable(q_count) && $stable(head_data))); // R3
  AST_RD_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !ovf_evt) |=> !status[1]); // R4
  AST_RD_SPARES_DR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !pop && status[0]) |=> status[0]); // R4
  AST_DR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && q_count == CW'(1) && !frame_push) |=> !status[0]); // R2
  AST_BRK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    brk_idle |-> !frame_push); // R9
  AST_BRK_ENTRY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_push && push_brk) |-> (!push_frm && !push_par)); // R8
  AST_PAR_WAITS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_push && q_count != '0 && !pop && !status_rd) |=> (status[2] == $past(status[2]))); // R12
endmodule

bind uart_rx_lsr uart_rx_lsr_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pop(pop), .status_rd(status_rd),
  .status(status), .head_data(head_data), .ovf_evt(ovf_evt),
  .frame_push(frame_push), .push_brk(frame_entry.brk),
  .push_frm(frame_entry.frm), .push_par(frame_entry.par),
  .brk_idle(brk_idle), .q_count(q_count)
);

// File: tb/uart_rx_lsr_tb.sv
`timescale 1ns/1ps
module uart_rx_lsr_tb;
  logic       clk, rst_n, tick, rx, par_en, par_odd, pop, status_rd;
  logic [1:0] data_len;
  logic [7:0] head_data;
  logic [4:0] status;
  int checks, errors;
  bit done;

  uart_rx_lsr u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx), .data_len(data_len),
    .par_en(par_en), .par_odd(par_odd), .pop(pop), .status_rd(status_rd),
    .head_data(head_data), .status(status)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {data, len, pen, podd, flip, exp_head, exp_status}
  localparam int NV = 6;
  localparam logic [25:0] VEC [NV] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 5'h01},
    {8'h3F, 2'd0, 1'b0, 1'b0, 1'b0, 8'h1F, 5'h01},
    {8'h55, 2'd1, 1'b1, 1'b0, 1'b0, 8'h15, 5'h01},
    {8'h7E, 2'd2, 1'b1, 1'b1, 1'b0, 8'h7E, 5'h01},
    {8'hC3, 2'd3, 1'b1, 1'b0, 1'b1, 8'hC3, 5'h05},
    {8'h09, 2'd0, 1'b1, 1'b1, 1'b1, 8'h09, 5'h05}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    rx = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input logic [1:0] len, input logic pen,
                           input logic podd, input logic flip, input logic stopv);
    logic p;
    data_len = len; par_en = pen; par_odd = podd;
    p = podd ^ flip;
    bit_out(1'b0);
    for (int i = 0; i < int'(len) + 5; i++) begin
      p = p ^ d[i];
      bit_out(d[i]);
    end
    if (pen) bit_out(p);
    bit_out(stopv);
  endtask

  task automatic strobe(input logic do_pop, input logic do_rd);
    pop = do_pop; status_rd = do_rd;
    @(negedge clk);
    pop = 1'b0; status_rd = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; tick = 1'b1; rx = 1'b1; pop = 1'b0; status_rd = 1'b0;
    data_len = 2'd3; par_en = 1'b0; par_odd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 status after reset", 32'(status), 32'h00);
    chk("R1 head after reset", 32'(head_data), 32'h00);

    // formats and parity: R11 R5
    for (int v = 0; v < NV; v++) begin
      send_char(VEC[v][25:18], VEC[v][17:16], VEC[v][15], VEC[v][14], VEC[v][13], 1'b1);
      bit_out(1'b1);
      chk("R11 head data", 32'(head_data), 32'(VEC[v][12:5]));
      chk("R5 status", 32'(status), 32'(VEC[v][4:0]));
      strobe(1'b1, 1'b1);
      chk("R2 empty after pop", 32'(status), 32'h00);
    end

    // R10 glitch on the line
    rx = 1'b0; repeat (4) @(negedge clk);
    bit_out(1'b1); bit_out(1'b1);
    chk("R10 glitch ignored", 32'(status), 32'h00);

    // R6 R7 framing error then resync
    send_char(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) bit_out(8'h3C >> i);
    bit_out(1'b1); bit_out(1'b1);
    chk("R6 framing status", 32'(status), 32'h09);
    chk("R6 framing head", 32'(head_data), 32'h81);
    strobe(1'b1, 1'b1);
    chk("R7 resync head", 32'(head_data), 32'h3C);
    chk("R7 resync status", 32'(status), 32'h01);
    strobe(1'b1, 1'b1);
    chk("R2 empty again", 32'(status), 32'h00);

    // R8 R9 break
    data_len = 2'd3; par_en = 1'b0;
    rx = 1'b0; repeat (400) @(negedge clk);
    chk("R8 break status", 32'(status), 32'h11);
    chk("R8 break head", 32'(head_data), 32'h00);
    bit_out(1'b1); bit_out(1'b1);
    strobe(1'b1, 1'b1);
    chk("R9 single break entry", 32'(status), 32'h00);

    // R12 error flag waits for head
    send_char(8'h11, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    send_char(8'h22, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1);
    bit_out(1'b1);
    chk("R12 flag hidden behind head", 32'(status), 32'h01);
    strobe(1'b1, 1'b0);
    chk("R12 flag at head", 32'(status), 32'h05);
    chk("R12 head data", 32'(head_data), 32'h22);
    strobe(1'b1, 1'b1);
    chk("R4 read clears parity", 32'(status), 32'h00);

    // R3 overrun
    for (int i = 0; i < 17; i++) send_char(8'(i + 8'h40), 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    bit_out(1'b1);
    chk("R3 overrun status", 32'(status), 32'h03);
    chk("R3 head kept", 32'(head_data), 32'h40);
    strobe(1'b0, 1'b1);
    chk("R4 read clears overrun keeps ready", 32'(status), 32'h01);
    for (int i = 0; i < 15; i++) strobe(1'b1, 1'b0);
    chk("R3 last stored entry", 32'(head_data), 32'h4F);
    chk("R2 ready with one left", 32'(status), 32'h01);
    strobe(1'b1, 1'b0);
    chk("R2 ready drops when empty", 32'(status), 32'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule